// File: doc/BRIEF.md
# Ping-Pong Cell Histogram Accumulator

The accumulator builds per-cell orientation histograms for one horizontal strip of image cells while the finished histograms of the strip before it are drained by a downstream stage. Each incoming vote carries a cell column, an orientation bin and a gradient magnitude. The magnitude is added into a running total held at the location formed by the column (upper address bits) joined to the bin (lower address bits).

Two identical banks take turns. One bank does read-modify-write accumulation of votes. The other answers readout requests and zeroes every location as it hands the value out, so it is empty again when its turn to accumulate comes back. The roles swap in the cycle where the row-toggle input differs from its value in the previous cycle. Forwarding of the most recent write per bank covers back-to-back updates of one location, and it also covers a readout or a vote that lands just after a swap. Neither case relies on a write-first memory mode.

Top module: `cellhist_pingpong`

## Requirements
- R1: After reset the first accumulating bank is bank A, rd_valid_o and rd_data_o are 0, and every readout location of both banks returns 0.
- R2: A vote with vote_valid_i high and vote_bin_i below NUM_BINS (default 9) adds vote_mag_i to the accumulating bank at address {vote_col_i, vote_bin_i}, with the column in the upper COL_W bits and the bin in the lower BIN_W bits. Other addresses are not changed.
- R3: Totals are SUM_W bits unsigned (default 16). A sum that would exceed 0xFFFF stays at 0xFFFF.
- R4: A vote whose bin is NUM_BINS or above changes no location.
- R5: A readout request (rd_en_i high with rd_addr_i) is answered in the next cycle with rd_valid_o high and rd_data_o holding the total. In a cycle with no answer, rd_valid_o is 0 and rd_data_o is 0.
- R6: Each readout sets the location it read to 0, so a second readout of that location in the same strip returns 0.
- R7: Every change of row_toggle_i, in either direction, swaps the banks in that same cycle. Votes from that cycle on go to the other bank, and readouts return the strip that has just finished.
- R8: Votes to one address in consecutive cycles are all counted. No update is lost to the one-cycle read latency.
- R9: A readout issued in the swap cycle returns the finished bank's total, including a vote issued in the cycle just before the swap.
- R10: A location cleared by a readout in the cycle before a swap starts the new strip at 0, even when a vote reaches it in the swap cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vote_valid_i | input | 1 | Vote present this cycle |
| vote_col_i | input | COL_W | Cell column of the vote |
| vote_bin_i | input | BIN_W | Orientation bin of the vote |
| vote_mag_i | input | MAG_W | Gradient magnitude to add |
| row_toggle_i | input | 1 | Flips on every change of cell row; any change swaps the banks |
| rd_en_i | input | 1 | Readout request |
| rd_addr_i | input | COL_W+BIN_W | Readout address {column, bin} |
| rd_valid_o | output | 1 | Readout answer present |
| rd_data_o | output | SUM_W | Readout total, 0 when no answer |

## Verification
The hardest situation to reach is the swap boundary. At that point a vote from the last cycle of a strip is still being written, a readout of the same location is issued in the swap cycle, and a vote in that cycle hits a location cleared by a readout issued one cycle earlier. Each of these is only visible if the stimulus lines up to the exact cycle. Directed sequences therefore place a vote, a toggle and a readout in adjacent cycles on a shared address, and a long burst of same-address votes drives a total into saturation. A random phase then mixes votes, out-of-range bins, readouts and toggles. In every cycle its output is compared against a behavioural model of the two banks.

// File: rtl/cellhist_pkg.sv
package cellhist_pkg;
  localparam int unsigned DEF_COL_W    = 6;
  localparam int unsigned DEF_BIN_W    = 4;
  localparam int unsigned DEF_NUM_BINS = 9;
  localparam int unsigned DEF_MAG_W    = 8;
  localparam int unsigned DEF_SUM_W    = 16;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/cellhist_store.sv
// One read port, one write port; the read is registered and sees the old value on a same-edge write.
module cellhist_store #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wkeep_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  live_q;
  logic [DATA_W-1:0] dout_q;
  logic              live_rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) dout_q <= mem_q[raddr_i];
  end

  // live bits stand in for a zeroed array after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= '0;
      live_rd_q <= 1'b0;
    end else begin
      if (we_i) live_q[waddr_i] <= wkeep_i;
      if (re_i) live_rd_q <= live_q[raddr_i];
    end
  end

  assign rdata_o = live_rd_q ? dout_q : '0;
endmodule

// File: rtl/cellhist_bank.sv
module cellhist_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wkeep_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ram_data;
  logic [ADDR_W-1:0] raddr_q;
  logic              wb_vld_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  cellhist_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (re_i),
    .raddr_i(raddr_i),
    .we_i   (we_i),
    .waddr_i(waddr_i),
    .wdata_i(wdata_i),
    .wkeep_i(wkeep_i),
    .rdata_o(ram_data)
  );

  // last write kept for one-deep forwarding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raddr_q   <= '0;
      wb_vld_q  <= 1'b0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
    end else begin
      if (re_i) raddr_q <= raddr_i;
      if (we_i) begin
        wb_vld_q  <= 1'b1;
        wb_addr_q <= waddr_i;
        wb_data_q <= wdata_i;
      end
    end
  end

  assign rdata_o = (wb_vld_q && wb_addr_q == raddr_q) ? wb_data_q : ram_data;
endmodule

// File: rtl/cellhist_pingpong.sv
module cellhist_pingpong
  import cellhist_pkg::*;
#(
  parameter int unsigned COL_W    = DEF_COL_W,
  parameter int unsigned BIN_W    = DEF_BIN_W,
  parameter int unsigned NUM_BINS = DEF_NUM_BINS,
  parameter int unsigned MAG_W    = DEF_MAG_W,
  parameter int unsigned SUM_W    = DEF_SUM_W,
  localparam int unsigned ADDR_W  = COL_W + BIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vote_valid_i,
  input  logic [COL_W-1:0]  vote_col_i,
  input  logic [BIN_W-1:0]  vote_bin_i,
  input  logic [MAG_W-1:0]  vote_mag_i,
  input  logic              row_toggle_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [SUM_W-1:0]  rd_data_o
);
  localparam int unsigned NBANK = 2;

  logic       row_tog_q;
  bank_e      acc_sel_q;
  logic       swap_now;
  bank_e      acc_sel;
  bank_e      rd_sel;
  logic       vote_ok;
  logic [ADDR_W-1:0] vaddr;

  logic              vs1_valid;
  bank_e             vs1_bank;
  logic [ADDR_W-1:0] vs1_addr;
  logic [MAG_W-1:0]  vs1_mag;
  logic              rs1_valid;
  bank_e             rs1_bank;
  logic [ADDR_W-1:0] rs1_addr;

  logic [SUM_W-1:0] vote_old;
  logic [SUM_W:0]   sum_ext;
  logic [SUM_W-1:0] new_sum;

  logic [NBANK-1:0]             b_re;
  logic [NBANK-1:0]             b_we;
  logic [NBANK-1:0]             b_keep;
  logic [NBANK-1:0][ADDR_W-1:0] b_raddr;
  logic [NBANK-1:0][ADDR_W-1:0] b_waddr;
  logic [NBANK-1:0][SUM_W-1:0]  b_wdata;
  logic [NBANK-1:0][SUM_W-1:0]  b_rdata;

  // role swap takes effect in the toggle cycle itself
  assign swap_now = row_toggle_i ^ row_tog_q;
  assign acc_sel  = bank_e'(acc_sel_q ^ swap_now);
  assign rd_sel   = bank_e'(~acc_sel);
  assign vote_ok  = vote_valid_i && ({1'b0, vote_bin_i} < (BIN_W+1)'(NUM_BINS));
  assign vaddr    = {vote_col_i, vote_bin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_tog_q <= 1'b0;
      acc_sel_q <= BANK_A;
      vs1_valid <= 1'b0;
      vs1_bank  <= BANK_A;
      vs1_addr  <= '0;
      vs1_mag   <= '0;
      rs1_valid <= 1'b0;
      rs1_bank  <= BANK_A;
      rs1_addr  <= '0;
    end else begin
      row_tog_q <= row_toggle_i;
      acc_sel_q <= acc_sel;
      vs1_valid <= vote_ok;
      vs1_bank  <= acc_sel;
      vs1_addr  <= vaddr;
      vs1_mag   <= vote_mag_i;
      rs1_valid <= rd_en_i;
      rs1_bank  <= rd_sel;
      rs1_addr  <= rd_addr_i;
    end
  end

  assign vote_old = b_rdata[vs1_bank];
  assign sum_ext  = {1'b0, vote_old} + {{(SUM_W+1-MAG_W){1'b0}}, vs1_mag};
  assign new_sum  = sum_ext[SUM_W] ? {SUM_W{1'b1}} : sum_ext[SUM_W-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic is_acc;
    logic vote_wr;
    assign is_acc     = (acc_sel == bank_e'(b));
    assign vote_wr    = vs1_valid && (vs1_bank == bank_e'(b));
    assign b_re[b]    = is_acc ? vote_ok : rd_en_i;
    assign b_raddr[b] = is_acc ? vaddr : rd_addr_i;
    // stage-1 vote and stage-1 clear always target different banks
    assign b_we[b]    = vote_wr || (rs1_valid && (rs1_bank == bank_e'(b)));
    assign b_waddr[b] = vote_wr ? vs1_addr : rs1_addr;
    assign b_wdata[b] = vote_wr ? new_sum : '0;
    assign b_keep[b]  = vote_wr;

    cellhist_bank #(
      .ADDR_W(ADDR_W),
      .DATA_W(SUM_W)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .re_i   (b_re[b]),
      .raddr_i(b_raddr[b]),
      .we_i   (b_we[b]),
      .waddr_i(b_waddr[b]),
      .wdata_i(b_wdata[b]),
      .wkeep_i(b_keep[b]),
      .rdata_o(b_rdata[b])
    );
  end

  assign rd_valid_o = rs1_valid;
  assign rd_data_o  = rs1_valid ? b_rdata[rs1_bank] : '0;
endmodule

// File: rtl/cellhist_checker.sv
module cellhist_checker #(
  parameter int unsigned BIN_W    = 4,
  parameter int unsigned NUM_BINS = 9,
  parameter int unsigned SUM_W    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic [SUM_W-1:0] rd_data_o,
  input logic             row_toggle_i,
  input logic             row_tog_q,
  input logic             acc_sel_q,
  input logic             vs1_valid,
  input logic             vs1_bank,
  input logic [BIN_W-1:0] vs1_bin,
  input logic             rs1_valid,
  input logic             rs1_bank,
  input logic [SUM_W-1:0] vote_old,
  input logic [SUM_W-1:0] new_sum
);
  assert_rd_answer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_rd_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && rd_data_o == '0));
  assert_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_toggle_i != row_tog_q) |=> (acc_sel_q != $past(acc_sel_q)));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_toggle_i == row_tog_q) |=> $stable(acc_sel_q));
  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs1_valid |-> (new_sum >= vote_old));
  assert_bin_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs1_valid |-> ({1'b0, vs1_bin} < (BIN_W+1)'(NUM_BINS)));
  assert_bank_split_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vs1_valid && rs1_valid && vs1_bank == rs1_bank));
endmodule

bind cellhist_pingpong cellhist_checker #(
  .BIN_W   (BIN_W),
  .NUM_BINS(NUM_BINS),
  .SUM_W   (SUM_W)
) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .row_toggle_i(row_toggle_i),
  .row_tog_q   (row_tog_q),
  .acc_sel_q   (acc_sel_q),
  .vs1_valid   (vs1_valid),
  .vs1_bank    (vs1_bank),
  .vs1_bin     (vs1_addr[BIN_W-1:0]),
  .rs1_valid   (rs1_valid),
  .rs1_bank    (rs1_bank),
  .vote_old    (vote_old),
  .new_sum     (new_sum)
);

// File: tb/cellhist_pingpong_bench.sv
module cellhist_pingpong_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 6;
  localparam int BIN_W = 4;
  localparam int NUM_BINS = 9;
  localparam int MAG_W = 8;
  localparam int SUM_W = 16;
  localparam int ADDR_W = COL_W + BIN_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vote_valid = 1'b0;
  logic [COL_W-1:0] vote_col = '0;
  logic [BIN_W-1:0] vote_bin = '0;
  logic [MAG_W-1:0] vote_mag = '0;
  logic row_tog = 1'b0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic rd_valid;
  logic [SUM_W-1:0] rd_data;

  int model [2][DEPTH];
  int m_acc = 0;
  logic m_tog = 1'b0;
  logic exp_v = 1'b0;
  int exp_d = 0;
  string tag = "R1";
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cellhist_pingpong u_cellhist_pingpong (
    .clk_i(clk), .rst_ni(rst_n),
    .vote_valid_i(vote_valid), .vote_col_i(vote_col), .vote_bin_i(vote_bin), .vote_mag_i(vote_mag),
    .row_toggle_i(row_tog), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  // behavioural reference of two banks
  always @(posedge clk) begin
    if (rst_n) begin
      int sel;
      int a;
      sel = m_acc ^ int'(row_tog != m_tog);
      exp_v = rd_en;
      exp_d = 0;
      if (rd_en) begin
        exp_d = model[1-sel][int'(rd_addr)];
        model[1-sel][int'(rd_addr)] = 0;
      end
      if (vote_valid && int'(vote_bin) < NUM_BINS) begin
        a = int'(vote_col) * (1 << BIN_W) + int'(vote_bin);
        model[sel][a] = model[sel][a] + int'(vote_mag);
        if (model[sel][a] > 65535) model[sel][a] = 65535;
      end
      m_tog = row_tog;
      m_acc = sel;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (rd_valid !== exp_v || int'(rd_data) !== exp_d) begin
        n_fail++;
        $display("FAIL %s model compare: valid %0b data %0d, expected valid %0b data %0d",
                 tag, rd_valid, rd_data, exp_v, exp_d);
      end
    end
  end

  task automatic chk(input string t, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic vote(input int col, input int bin, input int mag);
    vote_valid = 1'b1;
    vote_col = COL_W'(col);
    vote_bin = BIN_W'(bin);
    vote_mag = MAG_W'(mag);
    @(negedge clk);
    vote_valid = 1'b0;
  endtask

  task automatic swap();
    row_tog = ~row_tog;
    @(negedge clk);
  endtask

  task automatic read_one(input int col, input int bin, input int exp, input string t);
    rd_en = 1'b1;
    rd_addr = ADDR_W'(col * (1 << BIN_W) + bin);
    @(negedge clk);
    rd_en = 1'b0;
    chk(t, rd_valid ? int'(rd_data) : -1, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) model[b][a] = 0;
    idle(3);
    chk("R1 reset valid", int'(rd_valid), 0);
    chk("R1 reset data", int'(rd_data), 0);
    rst_n = 1'b1;
    idle(2);
    tag = "R1";
    read_one(0, 0, 0, "R1 empty bank");
    read_one(63, 8, 0, "R1 empty bank");

    tag = "R2";
    vote(3, 2, 10); idle(2);
    vote(3, 2, 7); idle(1);
    vote(5, 0, 200);
    vote(63, 8, 1);
    idle(2);
    swap();
    read_one(3, 2, 17, "R2 sum");
    read_one(5, 0, 200, "R2 single");
    read_one(63, 8, 1, "R2 last col last bin");
    read_one(3, 3, 0, "R2 neighbour untouched");
    tag = "R6";
    read_one(3, 2, 0, "R6 cleared on read");

    tag = "R8";
    for (int i = 0; i < 4; i++) vote(7, 1, 5);
    vote(8, 1, 11); vote(9, 1, 4); vote(8, 1, 11);
    tag = "R4";
    vote(10, 9, 50); vote(10, 15, 60); vote(10, 0, 1);
    idle(1);
    swap();
    read_one(7, 1, 20, "R8 back-to-back");
    read_one(8, 1, 22, "R8 alternating");
    read_one(9, 1, 4, "R8 alternating");
    read_one(10, 9, 0, "R4 bin 9 dropped");
    read_one(10, 15, 0, "R4 bin 15 dropped");
    read_one(10, 0, 1, "R4 valid bin kept");

    tag = "R3";
    for (int i = 0; i < 300; i++) vote(2, 4, 255);
    tag = "R9";
    vote(2, 5, 9);
    row_tog = ~row_tog;
    rd_en = 1'b1;
    rd_addr = ADDR_W'(2 * 16 + 5);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 read in swap cycle", rd_valid ? int'(rd_data) : -1, 9);
    tag = "R7";
    read_one(7, 1, 0, "R7 other bank drained earlier");

    tag = "R10";
    rd_en = 1'b1;
    rd_addr = ADDR_W'(2 * 16 + 4);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R3 saturated total", rd_valid ? int'(rd_data) : -1, 65535);
    row_tog = ~row_tog;
    vote_valid = 1'b1; vote_col = 6'd2; vote_bin = 4'd4; vote_mag = 8'd3;
    @(negedge clk);
    vote_valid = 1'b0;
    idle(2);
    swap();
    read_one(2, 4, 3, "R10 restart from zero");

    tag = "R7";
    for (int c = 0; c < 3000; c++) begin
      vote_valid = ($urandom_range(0, 1) == 1);
      vote_col = COL_W'($urandom_range(0, 7));
      vote_bin = BIN_W'($urandom_range(0, 15));
      vote_mag = MAG_W'($urandom_range(0, 255));
      rd_en = ($urandom_range(0, 2) == 0);
      rd_addr = ADDR_W'($urandom_range(0, 127));
      if ($urandom_range(0, 39) == 0) row_tog = ~row_tog;
      @(negedge clk);
    end
    vote_valid = 1'b0;
    rd_en = 1'b0;
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule